// File: doc/BRIEF.md
# Oversampled Frame-Synced UART Receiver

This block receives 8-N-1 asynchronous serial characters by treating the line as a synchronous bit stream. A sample tick runs at three times the baud rate. The tick rate is set by a programmable divider. While the receiver is armed, a low level on the synchronized line at a sample tick is taken as a start bit. That tick opens the capture of a fixed-length word of 29 samples. Each data bit is recovered from the middle sample of its three samples.

The frame is one sample shorter than a full character, because only two of the three stop-bit samples are taken. The receiver is therefore armed again during the last third of the stop bit. A start bit from a sender whose clock runs slightly fast then begins the next frame at once, and the receiver does not drift. A completed byte is held in a one-entry buffer until it is read. A framing-error flag travels with the byte. A sticky overrun flag records any byte that replaced an unread one.

Top module: `sprx_uart_rx`

## Requirements
- R1: The sample tick repeats every 2*(div_i+1) system clocks while enabled, so one bit time is three ticks.
- R2: rx_i passes through two synchronizing flops. An armed receiver starts a frame at the first tick on which the synchronized line is low, and that tick supplies the first start-bit sample.
- R3: Counting samples from 0 at the start tick, data bit i (LSB first on the line) is sample 4+3*i. In the 29-sample word taken MSB-first, these are positions 24, 21, ..., 3, and position 24 gives bit 0.
- R4: A frame holds exactly 29 samples. valid_o rises one clock after the clock edge of the 29th sample tick.
- R5: The receiver is armed again from the tick after the 29th sample. A start bit that arrives a third of a bit early opens the next frame, and both bytes are received correctly.
- R6: valid_o and data_o hold until rd_i is high for one clock while valid_o is high. rd_i while valid_o is low has no effect.
- R7: ferr_o is 1 with a byte when either stop-bit sample (samples 27 and 28) was low. The byte is still delivered.
- R8: ovr_o is set and stays set when a byte completes while valid_o is high and rd_i is low. The new byte replaces the old one. ovr_clr_i clears ovr_o, but a setting event in the same clock wins. A completion in the same clock as rd_i sets no overrun.
- R9: While en_i is low, the tick counter is held and any frame in progress is dropped, so no byte is produced. After en_i rises, the first tick comes 2*(div_i+1) clocks later, which is within three ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Receiver enable |
| div_i | input | 16 | Tick divider; tick period is 2*(div_i+1) clocks |
| rx_i | input | 1 | Asynchronous serial line, idle high |
| rd_i | input | 1 | Read strobe that empties the byte buffer |
| ovr_clr_i | input | 1 | Clear strobe for the overrun flag |
| data_o | output | 8 | Received byte |
| valid_o | output | 1 | Byte buffer holds an unread byte |
| ferr_o | output | 1 | Framing error of the buffered byte |
| ovr_o | output | 1 | Sticky overrun flag |

## Verification
Frame completion can fall in the same clock as a read of the buffer, or in the same clock as a clear of the overrun flag. The bench provokes both by watching its reference model for a pending completion and pulsing rd_i or ovr_clr_i in exactly that clock. In the read case, the new byte must be shown with no overrun. In the clear case, ovr_o must remain set. The same reference model also judges every output on every clock, so both cases are checked cycle by cycle.

// File: rtl/sprx_pkg.sv
package sprx_pkg;
  localparam int DATA_W    = 8;
  localparam int OVS       = 3;
  localparam int FRAME_LEN = OVS * (DATA_W + 2) - 1;
  localparam int IDX_W     = $clog2(FRAME_LEN + 1);
  localparam int STOP_N    = OVS - 1;
endpackage

// File: rtl/sprx_tick.sv
module sprx_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W:0] cnt_q;
  logic [DIV_W:0] lim;

  assign lim    = {div_i, 1'b1};
  assign tick_o = en_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!en_i || tick_o)   cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  // R1
  tick_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/sprx_sync.sv
module sprx_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/sprx_frame.sv
module sprx_frame
  import sprx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic              line_i,
  output logic              done_o,
  output logic [DATA_W-1:0] byte_o,
  output logic              ferr_o
);
  logic                 busy_q;
  logic [IDX_W-1:0]     idx_q;
  logic [FRAME_LEN-1:0] sh_q;
  logic [FRAME_LEN-1:0] nxt;
  logic [DATA_W-1:0]    bits;
  logic                 last;

  assign nxt  = {sh_q[FRAME_LEN-2:0], line_i};
  assign last = (idx_q == IDX_W'(FRAME_LEN - 1));

  // middle sample of each data bit, word taken MSB-first
  for (genvar i = 0; i < DATA_W; i++) begin : g_pick
    localparam int POS = FRAME_LEN - 1 - (OVS + OVS / 2 + OVS * i);
    assign bits[i] = nxt[POS];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      sh_q   <= '1;
      done_o <= 1'b0;
      byte_o <= '0;
      ferr_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!en_i) begin
        busy_q <= 1'b0;
        idx_q  <= '0;
      end else if (tick_i) begin
        if (!busy_q) begin
          if (!line_i) begin
            busy_q <= 1'b1;
            idx_q  <= IDX_W'(1);
            sh_q   <= {{(FRAME_LEN-1){1'b1}}, 1'b0};
          end
        end else begin
          sh_q  <= nxt;
          idx_q <= idx_q + 1'b1;
          if (last) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
            done_o <= 1'b1;
            byte_o <= bits;
            ferr_o <= ~&nxt[STOP_N-1:0];
          end
        end
      end
    end
  end

  // R4
  frame_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(idx_q) == IDX_W'(FRAME_LEN - 1));
  // R5
  rearm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_q);
  // R9
  disabled_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!busy_q && !done_o));
endmodule

// File: rtl/sprx_buf.sv
module sprx_buf
  import sprx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              ferr_i,
  input  logic              rd_i,
  input  logic              ovr_clr_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              ferr_o,
  output logic              ovr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      ferr_o  <= 1'b0;
    end else if (done_i) begin
      valid_o <= 1'b1;
      data_o  <= byte_i;
      ferr_o  <= ferr_i;
    end else if (rd_i) begin
      valid_o <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          ovr_o <= 1'b0;
    else if (done_i && valid_o && !rd_i)  ovr_o <= 1'b1;
    else if (ovr_clr_i)                   ovr_o <= 1'b0;
  end

  // R8
  ovr_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && valid_o && !rd_i) |=> ovr_o);
  // R8
  ovr_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_o && !ovr_clr_i) |=> ovr_o);
  // R6
  valid_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !rd_i) |=> (valid_o && (done_i || $stable(data_o))) or (valid_o && $past(done_i)));
endmodule

// File: rtl/sprx_uart_rx.sv
module sprx_uart_rx
  import sprx_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              rx_i,
  input  logic              rd_i,
  input  logic              ovr_clr_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              ferr_o,
  output logic              ovr_o
);
  logic              tick;
  logic              line;
  logic              done;
  logic [DATA_W-1:0] byte_w;
  logic              ferr_w;

  sprx_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i (clk_i), .rst_ni (rst_ni), .en_i (en_i), .div_i (div_i), .tick_o (tick)
  );

  sprx_sync u_sync (
    .clk_i (clk_i), .rst_ni (rst_ni), .d_i (rx_i), .q_o (line)
  );

  sprx_frame u_frame (
    .clk_i (clk_i), .rst_ni (rst_ni), .en_i (en_i), .tick_i (tick), .line_i (line),
    .done_o (done), .byte_o (byte_w), .ferr_o (ferr_w)
  );

  sprx_buf u_buf (
    .clk_i (clk_i), .rst_ni (rst_ni), .done_i (done), .byte_i (byte_w), .ferr_i (ferr_w),
    .rd_i (rd_i), .ovr_clr_i (ovr_clr_i),
    .valid_o (valid_o), .data_o (data_o), .ferr_o (ferr_o), .ovr_o (ovr_o)
  );
endmodule

// File: tb/sprx_uart_rx_tb_top.sv
`timescale 1ns/1ps
module sprx_uart_rx_tb_top;
  localparam real CLK_NS = 20.0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b1;
  logic [15:0] div = 16'd1;
  logic        rx = 1'b1;
  logic        rd = 1'b0;
  logic        ovr_clr = 1'b0;
  logic [7:0]  data_o;
  logic        valid_o, ferr_o, ovr_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  always #(CLK_NS/2) clk = ~clk;

  sprx_uart_rx dut_i (
    .clk_i (clk), .rst_ni (rst_n), .en_i (en), .div_i (div), .rx_i (rx),
    .rd_i (rd), .ovr_clr_i (ovr_clr),
    .data_o (data_o), .valid_o (valid_o), .ferr_o (ferr_o), .ovr_o (ovr_o)
  );

  // behavioural reference model
  int       m_cnt;
  bit       m_s1, m_s2, m_busy, m_done, m_dferr;
  bit       q[$];
  bit [7:0] m_dbyte, m_data;
  bit       m_full, m_ferr, m_ovr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_s1 = 1; m_s2 = 1; m_busy = 0; m_done = 0; m_dferr = 0;
      m_dbyte = 0; m_data = 0; m_full = 0; m_ferr = 0; m_ovr = 0;
      q.delete();
    end else begin
      bit tick, n_done;
      tick = en && (m_cnt == 2 * int'(div) + 1);
      if (m_done) begin
        if (m_full && !rd) m_ovr = 1;
        else if (ovr_clr) m_ovr = 0;
        m_full = 1; m_data = m_dbyte; m_ferr = m_dferr;
      end else begin
        if (rd) m_full = 0;
        if (ovr_clr) m_ovr = 0;
      end
      n_done = 0;
      if (!en) begin
        m_busy = 0; q.delete();
      end else if (tick) begin
        if (!m_busy) begin
          if (!m_s2) begin m_busy = 1; q.delete(); q.push_back(1'b0); end
        end else begin
          q.push_back(m_s2);
          if (q.size() == 29) begin
            n_done = 1;
            for (int i = 0; i < 8; i++) m_dbyte[i] = q[4 + 3 * i];
            m_dferr = !(q[27] && q[28]);
            m_busy = 0;
          end
        end
      end
      m_done = n_done;
      m_cnt  = (!en || tick) ? 0 : m_cnt + 1;
      m_s2 = m_s1; m_s1 = rx;
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R4 valid timing", int'(valid_o), int'(m_full));
      chk("R8 overrun flag", int'(ovr_o), int'(m_ovr));
      if (m_full) begin
        chk("R3 data bits", int'(data_o), int'(m_data));
        chk("R7 framing flag", int'(ferr_o), int'(m_ferr));
      end
    end
  end

  task automatic clks(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(bit [7:0] b, int stop_clks, bit stop_val);
    int bt;
    bt = 6 * (int'(div) + 1);
    rx = 1'b0; clks(bt);
    for (int i = 0; i < 8; i++) begin rx = b[i]; clks(bt); end
    rx = stop_val; clks(stop_clks);
    rx = 1'b1;
  endtask

  task automatic pulse_rd();
    rd = 1'b1; clks(1); rd = 1'b0;
  endtask

  task automatic wait_valid();
    int guard;
    guard = 0;
    while (!valid_o && guard < 2000) begin clks(1); guard++; end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_NS * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    clks(3);
    rst_n = 1'b1;
    clks(2);
    chk("R6 reset valid", int'(valid_o), 0);
    chk("R8 reset overrun", int'(ovr_o), 0);

    // R9: disabled receiver ignores a full character
    en = 1'b0; clks(5);
    send(8'h3C, 12, 1'b1); clks(40);
    chk("R9 disabled no byte", int'(valid_o), 0);
    en = 1'b1; clks(20);

    // R2 / R3 basic byte
    send(8'hA5, 12, 1'b1); clks(30);
    chk("R2 start detected", int'(valid_o), 1);
    chk("R3 byte A5", int'(data_o), 'hA5);
    chk("R7 good stop", int'(ferr_o), 0);
    pulse_rd(); clks(1);
    chk("R6 read empties", int'(valid_o), 0);
    pulse_rd(); clks(1);
    chk("R6 read while empty", int'(valid_o), 0);
    chk("R6 read while empty ovr", int'(ovr_o), 0);

    // R1 other divider
    div = 16'd2; clks(20);
    send(8'h5A, 18, 1'b1); clks(40);
    chk("R1 div2 byte", int'(data_o), 'h5A);
    pulse_rd();
    div = 16'd1; clks(20);

    // R5 short stop bit, next start early
    fork
      begin send(8'h81, 10, 1'b1); send(8'h7E, 12, 1'b1); end
      begin
        wait_valid(); chk("R5 first byte", int'(data_o), 'h81); pulse_rd();
        wait_valid(); chk("R5 second byte", int'(data_o), 'h7E); pulse_rd();
      end
    join
    clks(20);
    chk("R5 no overrun", int'(ovr_o), 0);

    // R7 stop bit low in its first half
    send(8'h55, 6, 1'b0); rx = 1'b1; clks(40);
    chk("R7 framing set", int'(ferr_o), 1);
    chk("R7 byte delivered", int'(data_o), 'h55);
    pulse_rd(); clks(5);

    // R8 overrun and clear
    send(8'h11, 12, 1'b1); clks(12);
    send(8'h22, 12, 1'b1); clks(30);
    chk("R8 overrun set", int'(ovr_o), 1);
    chk("R8 newest kept", int'(data_o), 'h22);
    ovr_clr = 1'b1; clks(1); ovr_clr = 1'b0; clks(1);
    chk("R8 overrun cleared", int'(ovr_o), 0);
    pulse_rd(); clks(5);

    // R8 completion in the same clock as a read
    send(8'h33, 12, 1'b1); clks(12);
    fork
      send(8'h44, 12, 1'b1);
      begin
        while (!(m_done && m_full)) clks(1);
        rd = 1'b1; clks(1); rd = 1'b0;
      end
    join
    clks(30);
    chk("R8 read collision no ovr", int'(ovr_o), 0);
    chk("R8 read collision data", int'(data_o), 'h44);
    chk("R6 read collision valid", int'(valid_o), 1);
    pulse_rd(); clks(5);

    // R8 completion in the same clock as a clear
    send(8'h66, 12, 1'b1); clks(12);
    send(8'h67, 12, 1'b1); clks(12);
    fork
      send(8'h68, 12, 1'b1);
      begin
        while (!(m_done && m_full)) clks(1);
        ovr_clr = 1'b1; clks(1); ovr_clr = 1'b0;
      end
    join
    clks(30);
    chk("R8 set beats clear", int'(ovr_o), 1);
    ovr_clr = 1'b1; clks(1); ovr_clr = 1'b0;
    pulse_rd(); clks(5);

    // R9 frame dropped when disabled mid-character
    fork
      send(8'h0F, 12, 1'b1);
      begin clks(40); en = 1'b0; end
    join
    clks(10); en = 1'b1; clks(150);
    chk("R9 aborted frame", int'(valid_o), 0);

    // R9 ready soon after enable
    send(8'hC3, 12, 1'b1); clks(30);
    chk("R9 byte after enable", int'(data_o), 'hC3);
    pulse_rd(); clks(10);

    finish_run();
  end
endmodule